// File: doc/BRIEF.md
# Runtime-Sized Radix-2 FFT Engine

This block computes a forward discrete Fourier transform of complex fixed-point samples. It works in place and runs radix-2 decimation-in-time butterflies one after another. A 3-bit size code chooses the transform length each time a frame starts: 2048, 1024, 512, 256 or 128 points. Every length uses the same working memory, the same butterfly and the same quarter-wave twiddle table. Changing the length is therefore a matter of presenting a different code with the next start pulse. Nothing is reloaded and no hardware changes.

The host writes N samples into the working memory at addresses 0 to N-1 while the engine is idle, then pulses start. The engine runs three phases in order:
- It reorders the samples by bit reversal over log2(N) address bits.
- It steps through the stages. Within each stage it steps through the groups of butterflies that share one twiddle factor, then through every butterfly in that group.
- It raises done. Bin k of the result can then be read at address k.

Each butterfly halves its outputs, so the result equals the DFT divided by N.

Top module: `fft_runtime_core`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are both 0.
- R2: A start pulse while idle with a size code from 0 to 4 makes busy 1 at the next clock edge and clears done. The transform length is 2048 shifted right by the code, over 11 minus the code stages.
- R3: A start pulse with a size code from 5 to 7 is ignored. Busy stays 0, done keeps its value and the memory contents are unchanged.
- R4: Input sample n is stored at address n. After done, bin k of the forward transform is at address k (natural order). The memory word packs the real part in its upper 16 bits and the imaginary part in its lower 16 bits.
- R5: Every butterfly scales its two outputs by 1/2 with rounding, so the result is the DFT divided by N. An impulse of amplitude A gives bins of magnitude A/N.
- R6: The size code is captured on the accepted start pulse. Changes on the mode input while busy do not affect the frame in progress.
- R7: A new frame with a different size code may start on any cycle after done, with no reload. It transforms whatever the memory then holds.
- R8: Done rises one cycle after the final write, while busy falls. Done stays 1 until the next accepted start. A start pulse while busy is ignored.
- R9: Host writes presented while busy are discarded.
- R10: The transform uses the forward sign, exp(-j2πnk/N). A tone at positive frequency bin b lands at address b, not at N-b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the control state |
| mode | input | 3 | Size code; N = 2048 >> mode, valid 0 to 4 |
| start | input | 1 | Launches a transform when idle and mode is valid |
| busy | output | 1 | Transform in progress |
| done | output | 1 | Result ready; held until the next accepted start |
| wrEn | input | 1 | Host write enable, honoured only while idle |
| wrAddr | input | 11 | Host write address |
| wrRe | input | 16 | Real part of the sample written, signed |
| wrIm | input | 16 | Imaginary part of the sample written, signed |
| rdAddr | input | 11 | Read address |
| rdRe | output | 16 | Real part at rdAddr, one cycle after the address |
| rdIm | output | 16 | Imaginary part at rdAddr, one cycle after the address |

## Verification
The properties assume two things of the inputs: that start is a short pulse whose mode value is meaningful on the cycle it is high, and that rstN is asserted before the first accepted frame. The stimulus raises start for exactly one cycle and keeps every loaded sample's complex magnitude well below full scale, so the halving butterflies never wrap. Deliberate violations of the handshake are limited to the cases the requirements cover: a start pulse and a host write issued mid-frame, a mode change while busy, and out-of-range size codes.

// File: rtl/fft_rt_pkg.sv
`timescale 1ns/1ps
package fft_rt_pkg;
  localparam int P_LOG_MAX    = 11;  // log2 of the largest transform
  localparam int P_SAMPLE_W   = 16;
  localparam int P_TW_W       = 16;
  localparam int P_MODE_W     = 3;
  localparam int P_MODE_COUNT = 5;

  typedef struct packed {
    logic capture;  // latch the two results of this cycle
    logic useBfly;  // butterfly results, else plain swap
    logic writeA;   // store latched A at addrA
    logic writeB;   // store latched B at addrB
  } engStrobe_t;
endpackage

// File: rtl/fft_twiddle_rom.sv
`timescale 1ns/1ps
module fft_twiddle_rom import fft_rt_pkg::*; #(
  parameter int LOG_MAX = P_LOG_MAX,
  parameter int TW_W    = P_TW_W
) (
  input  logic [LOG_MAX-2:0]      twIdx,
  output logic signed [TW_W-1:0]  wRe,
  output logic signed [TW_W-1:0]  wIm
);
  localparam int  QTR   = 1 << (LOG_MAX - 2);
  localparam real PI    = 3.14159265358979;
  localparam real SCALE = (2.0 ** (TW_W - 1)) - 1.0;

  logic signed [TW_W-1:0] cosTab [QTR+1];

  for (genvar g = 0; g <= QTR; g++) begin : gTab
    localparam real ANG = PI * real'(g) / real'(2 * QTR);
    localparam int  VAL = int'($cos(ANG) * SCALE);
    assign cosTab[g] = TW_W'(VAL);
  end

  logic [LOG_MAX-2:0] lowIdx, compIdx;
  logic signed [TW_W-1:0] cosV, sinV;

  always_comb begin
    lowIdx  = {1'b0, twIdx[LOG_MAX-3:0]};
    compIdx = (LOG_MAX-1)'(QTR) - lowIdx;
    if (!twIdx[LOG_MAX-2]) begin
      cosV = cosTab[lowIdx];
      sinV = cosTab[compIdx];
    end else begin
      cosV = -cosTab[compIdx];
      sinV = cosTab[lowIdx];
    end
    wRe = cosV;
    wIm = -sinV;   // forward transform: exp(-j*theta)
  end
endmodule

// File: rtl/fft_ctrl.sv
`timescale 1ns/1ps
module fft_ctrl import fft_rt_pkg::*; #(
  parameter int LOG_MAX    = P_LOG_MAX,
  parameter int MODE_W     = P_MODE_W,
  parameter int MODE_COUNT = P_MODE_COUNT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [MODE_W-1:0]  mode,
  output logic               busy,
  output logic               done,
  output engStrobe_t         strobe,
  output logic [LOG_MAX-1:0] addrA,
  output logic [LOG_MAX-1:0] addrB,
  output logic [LOG_MAX-2:0] twIdx
);
  localparam int STG_W = $clog2(LOG_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_BR_RD, S_BR_WA, S_BR_WB, S_BF_RD, S_BF_WA, S_BF_WB
  } state_t;

  state_t             state;
  logic [MODE_W-1:0]  modeQ;
  logic [LOG_MAX-1:0] idx, grp, base, span, revIdx;
  logic [STG_W-1:0]   stage;
  logic [LOG_MAX:0]   npts, step;
  logic modeOk, lastIdx, lastInner, lastGrp, lastStage;

  function automatic logic [LOG_MAX-1:0] bitRev(input logic [LOG_MAX-1:0] v);
    logic [LOG_MAX-1:0] r;
    for (int b = 0; b < LOG_MAX; b++) r[b] = v[LOG_MAX-1-b];
    return r;
  endfunction

  always_comb begin
    modeOk    = mode < MODE_W'(MODE_COUNT);
    npts      = {1'b1, {LOG_MAX{1'b0}}} >> modeQ;
    span      = LOG_MAX'(1) << stage;
    step      = {span, 1'b0};
    revIdx    = bitRev(idx) >> modeQ;
    lastIdx   = ({1'b0, idx} == npts - 1'b1);
    lastInner = (({1'b0, base} + step) >= npts);
    lastGrp   = (grp == span - 1'b1);
    lastStage = (stage == STG_W'(LOG_MAX - 1) - STG_W'(modeQ));
    twIdx     = (LOG_MAX-1)'(grp << (STG_W'(LOG_MAX - 1) - stage));
    if (state == S_BR_RD || state == S_BR_WA || state == S_BR_WB) begin
      addrA = idx;
      addrB = revIdx;
    end else begin
      addrA = base + grp;
      addrB = base + grp + span;
    end
    strobe = '0;
    case (state)
      S_BR_RD:          strobe.capture = 1'b1;
      S_BF_RD:          begin strobe.capture = 1'b1; strobe.useBfly = 1'b1; end
      S_BR_WA, S_BF_WA: strobe.writeA = 1'b1;
      S_BR_WB, S_BF_WB: strobe.writeB = 1'b1;
      default:          ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      busy  <= 1'b0;
      done  <= 1'b0;
      modeQ <= '0;
      idx   <= '0;
      stage <= '0;
      grp   <= '0;
      base  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start && modeOk) begin
          modeQ <= mode;
          idx   <= '0;
          busy  <= 1'b1;
          done  <= 1'b0;
          state <= S_BR_RD;
        end
        S_BR_RD: begin
          if (idx < revIdx) state <= S_BR_WA;
          else if (lastIdx) begin
            stage <= '0;
            grp   <= '0;
            base  <= '0;
            state <= S_BF_RD;
          end else idx <= idx + 1'b1;
        end
        S_BR_WA: state <= S_BR_WB;
        S_BR_WB: begin
          idx   <= idx + 1'b1;
          state <= S_BR_RD;
        end
        S_BF_RD: state <= S_BF_WA;
        S_BF_WA: state <= S_BF_WB;
        S_BF_WB: begin
          state <= S_BF_RD;
          if (!lastInner) base <= base + step[LOG_MAX-1:0];
          else begin
            base <= '0;
            if (!lastGrp) grp <= grp + 1'b1;
            else begin
              grp <= '0;
              if (!lastStage) stage <= stage + 1'b1;
              else begin
                busy  <= 1'b0;
                done  <= 1'b1;
                state <= S_IDLE;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fft_datapath.sv
`timescale 1ns/1ps
module fft_datapath import fft_rt_pkg::*; #(
  parameter int LOG_MAX  = P_LOG_MAX,
  parameter int SAMPLE_W = P_SAMPLE_W,
  parameter int TW_W     = P_TW_W
) (
  input  logic                       clk,
  input  logic                       engBusy,
  input  engStrobe_t                 strobe,
  input  logic [LOG_MAX-1:0]         addrA,
  input  logic [LOG_MAX-1:0]         addrB,
  input  logic signed [TW_W-1:0]     wRe,
  input  logic signed [TW_W-1:0]     wIm,
  input  logic                       hostWrEn,
  input  logic [LOG_MAX-1:0]         hostAddr,
  input  logic signed [SAMPLE_W-1:0] hostRe,
  input  logic signed [SAMPLE_W-1:0] hostIm,
  input  logic [LOG_MAX-1:0]         rdAddr,
  output logic signed [SAMPLE_W-1:0] rdRe,
  output logic signed [SAMPLE_W-1:0] rdIm
);
  localparam int DEPTH  = 1 << LOG_MAX;
  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int PW     = SAMPLE_W + TW_W + 1;
  localparam int EW     = SAMPLE_W + 2;
  localparam logic signed [PW-1:0] RND_P = PW'(1) <<< (TW_W - 2);
  localparam logic signed [EW-1:0] RND_E = EW'(1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] wordA, wordB, regA, regB, bflyA, bflyB, rdWord;
  logic signed [SAMPLE_W-1:0] aRe, aIm, bRe, bIm;
  logic signed [PW-1:0] prRe, prIm;
  logic signed [EW-1:0] tRe, tIm, aReE, aImE;

  always_comb begin
    wordA = mem[addrA];
    wordB = mem[addrB];
    aRe = wordA[WORD_W-1:SAMPLE_W];
    aIm = wordA[SAMPLE_W-1:0];
    bRe = wordB[WORD_W-1:SAMPLE_W];
    bIm = wordB[SAMPLE_W-1:0];
    prRe = PW'(bRe) * PW'(wRe) - PW'(bIm) * PW'(wIm) + RND_P;
    prIm = PW'(bRe) * PW'(wIm) + PW'(bIm) * PW'(wRe) + RND_P;
    tRe  = EW'(prRe >>> (TW_W - 1));
    tIm  = EW'(prIm >>> (TW_W - 1));
    aReE = EW'(aRe);
    aImE = EW'(aIm);
    bflyA = {SAMPLE_W'((aReE + tRe + RND_E) >>> 1), SAMPLE_W'((aImE + tIm + RND_E) >>> 1)};
    bflyB = {SAMPLE_W'((aReE - tRe + RND_E) >>> 1), SAMPLE_W'((aImE - tIm + RND_E) >>> 1)};
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      regA <= strobe.useBfly ? bflyA : wordB;
      regB <= strobe.useBfly ? bflyB : wordA;
    end
    if (strobe.writeA)                mem[addrA]    <= regA;
    else if (strobe.writeB)           mem[addrB]    <= regB;
    else if (hostWrEn && !engBusy)    mem[hostAddr] <= {hostRe, hostIm};
    rdWord <= mem[rdAddr];
  end

  assign rdRe = rdWord[WORD_W-1:SAMPLE_W];
  assign rdIm = rdWord[SAMPLE_W-1:0];
endmodule

// File: rtl/fft_runtime_core.sv
`timescale 1ns/1ps
module fft_runtime_core import fft_rt_pkg::*; #(
  parameter int LOG_MAX    = P_LOG_MAX,
  parameter int SAMPLE_W   = P_SAMPLE_W,
  parameter int TW_W       = P_TW_W,
  parameter int MODE_W     = P_MODE_W,
  parameter int MODE_COUNT = P_MODE_COUNT
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [MODE_W-1:0]          mode,
  input  logic                       start,
  output logic                       busy,
  output logic                       done,
  input  logic                       wrEn,
  input  logic [LOG_MAX-1:0]         wrAddr,
  input  logic signed [SAMPLE_W-1:0] wrRe,
  input  logic signed [SAMPLE_W-1:0] wrIm,
  input  logic [LOG_MAX-1:0]         rdAddr,
  output logic signed [SAMPLE_W-1:0] rdRe,
  output logic signed [SAMPLE_W-1:0] rdIm
);
  engStrobe_t             strobe;
  logic [LOG_MAX-1:0]     addrA, addrB;
  logic [LOG_MAX-2:0]     twIdx;
  logic signed [TW_W-1:0] wRe, wIm;

  fft_ctrl #(.LOG_MAX(LOG_MAX), .MODE_W(MODE_W), .MODE_COUNT(MODE_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .busy(busy), .done(done),
    .strobe(strobe), .addrA(addrA), .addrB(addrB), .twIdx(twIdx));

  fft_twiddle_rom #(.LOG_MAX(LOG_MAX), .TW_W(TW_W)) u_rom (
    .twIdx(twIdx), .wRe(wRe), .wIm(wIm));

  fft_datapath #(.LOG_MAX(LOG_MAX), .SAMPLE_W(SAMPLE_W), .TW_W(TW_W)) u_dp (
    .clk(clk), .engBusy(busy), .strobe(strobe), .addrA(addrA), .addrB(addrB),
    .wRe(wRe), .wIm(wIm), .hostWrEn(wrEn), .hostAddr(wrAddr), .hostRe(wrRe),
    .hostIm(wrIm), .rdAddr(rdAddr), .rdRe(rdRe), .rdIm(rdIm));
endmodule

// File: rtl/fft_runtime_core_chk.sv
`timescale 1ns/1ps
module fft_runtime_core_chk #(
  parameter int MODE_W     = 3,
  parameter int MODE_COUNT = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [MODE_W-1:0] mode,
  input logic              busy,
  input logic              done
);
  p_launch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && mode < MODE_W'(MODE_COUNT)) |=> (busy && !done));

  p_bad_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && mode >= MODE_W'(MODE_COUNT)) |=> (!busy && $stable(done)));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rstN) !(busy && done));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !(start && mode < MODE_W'(MODE_COUNT))) |=> done);

  p_finish_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(busy) && !busy));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
endmodule

bind fft_runtime_core fft_runtime_core_chk #(.MODE_W(MODE_W), .MODE_COUNT(MODE_COUNT)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .mode(mode), .busy(busy), .done(done));

// File: tb/fft_runtime_core_tb.sv
`timescale 1ns/1ps
module fft_runtime_core_tb;
  localparam int LOGM = 11;
  localparam int SW   = 16;
  localparam int MAXN = 1 << LOGM;
  localparam int TOL  = 8;
  localparam int WATCH_CYC = 190000;
  localparam real PI = 3.14159265358979;

  typedef struct packed {
    logic [2:0]  mode;
    logic        isTone;
    logic [10:0] pos;
    logic [15:0] amp;
  } vec_t;
  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{3'd4, 1'b0, 11'd0,    16'd12800},
    '{3'd3, 1'b0, 11'd3,    16'd16000},
    '{3'd4, 1'b1, 11'd5,    16'd9000},
    '{3'd3, 1'b1, 11'd37,   16'd9000},
    '{3'd2, 1'b1, 11'd100,  16'd8000},
    '{3'd1, 1'b1, 11'd1000, 16'd8000},
    '{3'd0, 1'b1, 11'd1531, 16'd8000}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, wrEn = 1'b0;
  logic [2:0] mode = '0;
  logic [LOGM-1:0] wrAddr = '0, rdAddr = '0;
  logic signed [SW-1:0] wrRe = '0, wrIm = '0;
  logic signed [SW-1:0] rdRe, rdIm;
  logic busy, done;

  always #2.5 clk = ~clk;

  fft_runtime_core u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .start(start), .busy(busy), .done(done),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrRe(wrRe), .wrIm(wrIm),
    .rdAddr(rdAddr), .rdRe(rdRe), .rdIm(rdIm));

  int checks = 0, fails = 0;
  int xRe [MAXN], xIm [MAXN], gRe [MAXN], gIm [MAXN];
  real eRe [MAXN], eIm [MAXN], cT [MAXN], sT [MAXN];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic buildInput(input int n, input bit tone, input int pos, input int amp);
    for (int i = 0; i < MAXN; i++) begin xRe[i] = 0; xIm[i] = 0; end
    for (int i = 0; i < n; i++) begin
      if (tone) begin
        real th;
        th = 2.0 * PI * real'(pos) * real'(i) / real'(n);
        xRe[i] = int'(real'(amp) * $cos(th));
        xIm[i] = int'(real'(amp) * $sin(th));
      end else if (i == pos) xRe[i] = amp;
    end
  endtask

  task automatic loadMem(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = LOGM'(i); wrRe = SW'(xRe[i]); wrIm = SW'(xIm[i]);
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic startFrame(input int m);
    @(negedge clk);
    mode = 3'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic readMem(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rdAddr = LOGM'(k);
      @(negedge clk); gRe[k] = int'(rdRe); gIm[k] = int'(rdIm);
    end
  endtask

  task automatic refDft(input int n);
    for (int i = 0; i < n; i++) begin
      cT[i] = $cos(2.0 * PI * real'(i) / real'(n));
      sT[i] = $sin(2.0 * PI * real'(i) / real'(n));
    end
    for (int k = 0; k < n; k++) begin
      real ar, ai;
      ar = 0.0; ai = 0.0;
      for (int i = 0; i < n; i++) begin
        int p;
        p = (i * k) % n;
        ar += real'(xRe[i]) * cT[p] + real'(xIm[i]) * sT[p];
        ai += real'(xIm[i]) * cT[p] - real'(xRe[i]) * sT[p];
      end
      eRe[k] = ar / real'(n);
      eIm[k] = ai / real'(n);
    end
  endtask

  task automatic compareDft(input int n, input string tag);
    int badK, badAct, badExp;
    bit ok;
    ok = 1'b1; badK = 0; badAct = 0; badExp = 0;
    for (int k = 0; k < n && ok; k++) begin
      int er, ei;
      er = int'(eRe[k]); ei = int'(eIm[k]);
      if (gRe[k] - er > TOL || er - gRe[k] > TOL) begin
        ok = 1'b0; badK = k; badAct = gRe[k]; badExp = er;
      end else if (gIm[k] - ei > TOL || ei - gIm[k] > TOL) begin
        ok = 1'b0; badK = k; badAct = gIm[k]; badExp = ei;
      end
    end
    check(ok, tag, $sformatf("N=%0d bin %0d", n, badK), badAct, badExp);
  endtask

  initial begin
    repeat (WATCH_CYC) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WATCH_CYC);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", int'({busy, done}), 0);

    // table of vectors: impulses check R5 scaling, tones check R10 sign, all check R2 R4
    for (int v = 0; v < NVEC; v++) begin
      int n;
      n = MAXN >> VECS[v].mode;
      buildInput(n, VECS[v].isTone, int'(VECS[v].pos), int'(VECS[v].amp));
      loadMem(n);
      startFrame(int'(VECS[v].mode));
      check(busy == 1'b1 && done == 1'b0, "R2", "busy after start", int'(busy), 1);
      waitDone();
      readMem(n);
      refDft(n);
      compareDft(n, VECS[v].isTone ? "R2 R4 R10 tone" : "R2 R4 R5 impulse");
    end

    // R3: invalid size codes are ignored and leave memory intact
    begin
      logic doneBefore;
      buildInput(128, 1'b1, 7, 5000);
      loadMem(128);
      doneBefore = done;
      startFrame(5);
      check(busy == 1'b0, "R3", "busy after code 5", int'(busy), 0);
      startFrame(7);
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == doneBefore, "R3", "done after code 7",
            int'(done), int'(doneBefore));
      readMem(128);
      begin
        bit same;
        same = 1'b1;
        for (int i = 0; i < 128; i++)
          if (gRe[i] != xRe[i] || gIm[i] != xIm[i]) same = 1'b0;
        check(same, "R3", "memory untouched", int'(same), 1);
      end
    end

    // R6 R8 R9: mode change, extra start and host write during a frame
    buildInput(128, 1'b1, 9, 7000);
    loadMem(128);
    startFrame(4);
    repeat (10) @(negedge clk);
    mode = 3'd0; start = 1'b1; wrEn = 1'b1; wrAddr = LOGM'(5);
    wrRe = SW'(12345); wrIm = SW'(-12345);
    @(negedge clk);
    start = 1'b0; wrEn = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R8", "start while busy", int'(busy), 1);
    waitDone();
    check(busy == 1'b0, "R8", "busy at done", int'(busy), 0);
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R8", "done held", int'(done), 1);
    readMem(128);
    refDft(128);
    compareDft(128, "R6 R9 frame kept its size and data");

    // R7: back-to-back frames of different sizes, no reload between them
    buildInput(256, 1'b1, 20, 6000);
    loadMem(256);
    startFrame(4);
    waitDone();
    readMem(128);
    refDft(128);
    compareDft(128, "R7 first frame");
    for (int i = 0; i < 128; i++) begin xRe[i] = gRe[i]; xIm[i] = gIm[i]; end
    startFrame(3);
    check(busy == 1'b1, "R7", "second frame accepted", int'(busy), 1);
    waitDone();
    readMem(256);
    refDft(256);
    compareDft(256, "R7 second frame");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule